// File: doc/BRIEF.md
# LED Matrix Row-Scan Refresh Controller

This block keeps a 128 x 32 single-colour LED matrix module lit. The module has a serial video input: pixels go in one bit at a time on a dot clock, a strobe moves a finished row into the column drivers, and a separate row clock with a first-row marker steps the module's row pointer. The controller reads each row from an external frame-buffer read port with an asynchronous read, shifts it out, and repeats over all rows forever. One frame is 32 row periods long.

Each row period has a fixed schedule, timed by one row timer:
- The next row is shifted out while the row latched last time is lit.
- The drive enable is dropped.
- After a guard time the column strobe is pulsed.
- After another guard the row clock is pulsed. The first-row marker is held steady around its falling edge.
- After a last guard the enable returns.

While a row is lit, the enable is gated by an 8-bit brightness duty cycle. So no strobe edge and no row-clock edge ever happens while the drivers are on.

All timing figures are parameters counted in system clocks: the dot-clock half period, the guard time, the strobe width, the row-clock width and the row period. The defaults suit a 250 MHz system clock. They give a dot clock below 8 MHz, strobe and row-clock pulses of about 5 µs, 128 ns guards and about 70 frames per second.

Top module: `ledmx_refresh`

## Requirements
- R1: Each row period issues exactly 128 rising edges on `px_clk`. `px_clk` stays high for DOT_HALF clocks per bit and low for DOT_HALF clocks between bits, so the dot rate is the clock rate divided by 2*DOT_HALF.
- R2: During the shift of a row, `fb_row` carries that row and `fb_col` steps through 0 to 127. The value of `fb_pix` read for column c is the value on `px_data` at the c-th rising edge of `px_clk` (column 0 first). The value is passed unchanged: 1 lights the pixel and 0 turns it off.
- R3: `col_strobe` is low while pixels are shifted and is never high together with `px_clk`. It pulses high for exactly LATCH_CLKS clocks once per row, after all 128 bits of that row have been sent.
- R4: `drive_en` has been low for at least GUARD_CLKS clocks before every edge of `col_strobe` and of `row_step`. It stays low for at least GUARD_CLKS clocks after the last of these edges in a row period.
- R5: `row_step` pulses high for exactly STEP_CLKS clocks once per row. Its falling edges are exactly ROW_CLKS clocks apart.
- R6: Rows are latched in the order 0, 1, ..., ROWS-1, then the order wraps to 0. `frame_mark` is 1 at the falling edge of `row_step` only when the row just latched is row 0, and is 0 there for every other row. It does not change at that edge.
- R7: While reset is asserted, all six video outputs are 0. `drive_en` stays 0 until the first row has been shifted and latched.
- R8: Let L = ROW_CLKS - 3*GUARD_CLKS - LATCH_CLKS - STEP_CLKS. The lit interval holds L clock slots. In slot i (i from 0), `drive_en` is 1 exactly when (i mod 255) < `lum_level`. So a level of 0 gives no lit clocks and a level of 255 gives all L.
- R9: `lum_level` is sampled every clock. A new value applied while the display is blanked governs the whole of the next lit interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lum_level | input | 8 | Brightness duty level, 0 = dark, 255 = fully lit |
| fb_row | output | log2(ROWS) | Frame-buffer read row |
| fb_col | output | log2(COLS) | Frame-buffer read column |
| fb_pix | input | 1 | Pixel bit read at (fb_row, fb_col), same cycle |
| px_data | output | 1 | Serial pixel data to the module |
| px_clk | output | 1 | Dot clock; the module samples on the rising edge |
| col_strobe | output | 1 | Column latch pulse |
| frame_mark | output | 1 | First-row marker, sampled on the row_step fall |
| row_step | output | 1 | Row clock |
| drive_en | output | 1 | Display drive enable with brightness duty |

## Verification
Every video output is a register driven from the sequencer phase, so each output moves exactly one clock after the phase that calls for it. The bench therefore does not predict absolute times. It samples on falling clock edges and measures between protocol edges:
- pixel bits are captured at each `px_clk` rise and compared, when `col_strobe` falls, with the row that a scoreboard queue says is due;
- the `frame_mark` value is checked at the `row_step` fall;
- the row period, the pulse widths and the guard runs of `drive_en` are counted in clock samples.

A brightness value is applied at a strobe rise, while the display is blanked. The bench then expects its effect exactly one strobe-to-strobe window later, as a count of lit clocks computed from R8.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

  localparam int unsigned LUM_W = 8;

  typedef enum logic [2:0] {
    PH_SHIFT = 3'd0,
    PH_HOLD  = 3'd1,
    PH_PRE   = 3'd2,
    PH_LATCH = 3'd3,
    PH_MID   = 3'd4,
    PH_STEP  = 3'd5,
    PH_POST  = 3'd6
  } scan_ph_e;

  function automatic logic ph_is_lit(scan_ph_e p);
    return (p == PH_SHIFT) || (p == PH_HOLD);
  endfunction

  function automatic logic ph_marks(scan_ph_e p);
    return (p == PH_LATCH) || (p == PH_MID) || (p == PH_STEP) || (p == PH_POST);
  endfunction

endpackage

// File: rtl/ledmx_shift.sv
module ledmx_shift #(
  parameter int unsigned COLS     = 128,
  parameter int unsigned DOT_HALF = 16,
  localparam int unsigned COL_W   = $clog2(COLS),
  localparam int unsigned PH_W    = $clog2(2 * DOT_HALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             pix_i,
  output logic [COL_W-1:0] col_o,
  output logic             done_o,
  output logic             ser_o,
  output logic             dot_o
);

  localparam logic [PH_W-1:0]  PH_END  = PH_W'(2 * DOT_HALF - 1);
  localparam logic [PH_W-1:0]  PH_RISE = PH_W'(DOT_HALF);
  localparam logic [COL_W-1:0] COL_END = COL_W'(COLS - 1);

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             ser_q, ser_d;
  logic             dot_q, dot_d;
  logic             wrap;

  always_comb begin
    wrap   = (ph_q == PH_END);
    done_o = run_i && wrap && (col_q == COL_END);
    if (!run_i) begin
      ph_d  = '0;
      col_d = '0;
      ser_d = 1'b0;
    end else begin
      ph_d  = wrap ? '0 : ph_q + 1'b1;
      col_d = !wrap ? col_q : ((col_q == COL_END) ? '0 : col_q + 1'b1);
      ser_d = (ph_q == '0) ? pix_i : ser_q;
    end
    dot_d = run_i && (ph_q >= PH_RISE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      col_q <= '0;
      ser_q <= 1'b0;
      dot_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      col_q <= col_d;
      ser_q <= ser_d;
      dot_q <= dot_d;
    end
  end

  assign col_o = col_q;
  assign ser_o = ser_q;
  assign dot_o = dot_q;

  AST_SER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dot_q) |-> $stable(ser_q)); // R2

endmodule

// File: rtl/ledmx_pwm.sv
module ledmx_pwm import ledmx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             gate_i,
  input  logic [LUM_W-1:0] lum_i,
  output logic             en_o
);

  localparam logic [LUM_W-1:0] CNT_END = {{(LUM_W-1){1'b1}}, 1'b0};

  logic [LUM_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;

  always_comb begin
    if (clr_i || (cnt_q == CNT_END)) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
    en_d = gate_i && (cnt_q < lum_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

  AST_PWM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lum_i) == '0) |-> !en_q); // R8

  AST_PWM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_i) && ($past(lum_i) == '1)) |-> en_q); // R8

endmodule

// File: rtl/ledmx_seq.sv
module ledmx_seq import ledmx_pkg::*; #(
  parameter int unsigned ROWS       = 32,
  parameter int unsigned ROW_CLKS   = 111607,
  parameter int unsigned GUARD_CLKS = 32,
  parameter int unsigned LATCH_CLKS = 1280,
  parameter int unsigned STEP_CLKS  = 1280,
  localparam int unsigned ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_done_i,
  output scan_ph_e         ph_o,
  output logic [ROW_W-1:0] row_o,
  output logic             tmr_last_o,
  output logic             lit_ok_o
);

  localparam int unsigned TMR_W   = $clog2(ROW_CLKS);
  localparam int unsigned T_PRE   = ROW_CLKS - (3 * GUARD_CLKS + LATCH_CLKS + STEP_CLKS);
  localparam int unsigned T_LATCH = T_PRE + GUARD_CLKS;
  localparam int unsigned T_MID   = T_LATCH + LATCH_CLKS;
  localparam int unsigned T_STEP  = T_MID + GUARD_CLKS;
  localparam int unsigned T_POST  = T_STEP + STEP_CLKS;

  localparam logic [TMR_W-1:0] E_PRE   = TMR_W'(T_PRE - 1);
  localparam logic [TMR_W-1:0] E_LATCH = TMR_W'(T_LATCH - 1);
  localparam logic [TMR_W-1:0] E_MID   = TMR_W'(T_MID - 1);
  localparam logic [TMR_W-1:0] E_STEP  = TMR_W'(T_STEP - 1);
  localparam logic [TMR_W-1:0] E_POST  = TMR_W'(T_POST - 1);
  localparam logic [TMR_W-1:0] E_ROW   = TMR_W'(ROW_CLKS - 1);
  localparam logic [ROW_W-1:0] ROW_END = ROW_W'(ROWS - 1);

  scan_ph_e         ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             lit_q, lit_d;
  logic             last;

  always_comb begin
    last  = (tmr_q == E_ROW);
    tmr_d = last ? '0 : tmr_q + 1'b1;
    ph_d  = ph_q;
    unique case (ph_q)
      PH_SHIFT: if (shift_done_i)      ph_d = PH_HOLD;
      PH_HOLD:  if (tmr_q == E_PRE)    ph_d = PH_PRE;
      PH_PRE:   if (tmr_q == E_LATCH)  ph_d = PH_LATCH;
      PH_LATCH: if (tmr_q == E_MID)    ph_d = PH_MID;
      PH_MID:   if (tmr_q == E_STEP)   ph_d = PH_STEP;
      PH_STEP:  if (tmr_q == E_POST)   ph_d = PH_POST;
      PH_POST:  if (last)              ph_d = PH_SHIFT;
      default:                         ph_d = PH_SHIFT;
    endcase
    if ((ph_q == PH_POST) && last) row_d = (row_q == ROW_END) ? '0 : row_q + 1'b1;
    else                           row_d = row_q;
    lit_d = lit_q || (ph_q == PH_POST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SHIFT;
      tmr_q <= '0;
      row_q <= '0;
      lit_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      tmr_q <= tmr_d;
      row_q <= row_d;
      lit_q <= lit_d;
    end
  end

  assign ph_o       = ph_q;
  assign row_o      = row_q;
  assign tmr_last_o = last;
  assign lit_ok_o   = lit_q;

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_SHIFT) && ($past(ph_q) == PH_POST)) |->
      (row_q == (($past(row_q) == ROW_END) ? {ROW_W{1'b0}} : $past(row_q) + 1'b1))); // R6

  AST_SHIFT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_PRE) && ($past(ph_q) != PH_PRE)) |-> ($past(ph_q) == PH_HOLD)); // R3

endmodule

// File: rtl/ledmx_refresh.sv
module ledmx_refresh import ledmx_pkg::*; #(
  parameter int unsigned COLS       = 128,
  parameter int unsigned ROWS       = 32,
  parameter int unsigned DOT_HALF   = 16,
  parameter int unsigned ROW_CLKS   = 111607,
  parameter int unsigned GUARD_CLKS = 32,
  parameter int unsigned LATCH_CLKS = 1280,
  parameter int unsigned STEP_CLKS  = 1280,
  localparam int unsigned COL_W     = $clog2(COLS),
  localparam int unsigned ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LUM_W-1:0] lum_level,
  output logic [ROW_W-1:0] fb_row,
  output logic [COL_W-1:0] fb_col,
  input  logic             fb_pix,
  output logic             px_data,
  output logic             px_clk,
  output logic             col_strobe,
  output logic             frame_mark,
  output logic             row_step,
  output logic             drive_en
);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  scan_ph_e         ph;
  logic [ROW_W-1:0] row;
  logic             tmr_last, lit_ok, shift_done, gate;
  logic             strobe_q, strobe_d;
  logic             step_q, step_d;
  logic             mark_q, mark_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  ledmx_seq #(
    .ROWS(ROWS), .ROW_CLKS(ROW_CLKS), .GUARD_CLKS(GUARD_CLKS),
    .LATCH_CLKS(LATCH_CLKS), .STEP_CLKS(STEP_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_core_n), .shift_done_i(shift_done),
    .ph_o(ph), .row_o(row), .tmr_last_o(tmr_last), .lit_ok_o(lit_ok)
  );

  ledmx_shift #(.COLS(COLS), .DOT_HALF(DOT_HALF)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .run_i(ph == PH_SHIFT), .pix_i(fb_pix),
    .col_o(fb_col), .done_o(shift_done), .ser_o(px_data), .dot_o(px_clk)
  );

  assign gate = lit_ok && ph_is_lit(ph);

  ledmx_pwm u_pwm (
    .clk(clk), .rst_n(rst_core_n), .clr_i(tmr_last), .gate_i(gate),
    .lum_i(lum_level), .en_o(drive_en)
  );

  always_comb begin
    strobe_d = (ph == PH_LATCH);
    step_d   = (ph == PH_STEP);
    mark_d   = (row == '0) && ph_marks(ph);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      strobe_q <= 1'b0;
      step_q   <= 1'b0;
      mark_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      step_q   <= step_d;
      mark_q   <= mark_d;
    end
  end

  assign fb_row     = row;
  assign col_strobe = strobe_q;
  assign row_step   = step_q;
  assign frame_mark = mark_q;

  AST_STROBE_BLANK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (col_strobe != $past(col_strobe)) |-> (!drive_en && !$past(drive_en))); // R4

  AST_STEP_BLANK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (row_step != $past(row_step)) |-> (!drive_en && !$past(drive_en))); // R4

  AST_MARK_HELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(row_step) |-> $stable(frame_mark)); // R6

  AST_NO_DOT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_core_n)
    col_strobe |-> !px_clk); // R3

endmodule

// File: tb/sim_ledmx_refresh.sv
`timescale 1ns/1ps
module sim_ledmx_refresh;

  localparam int COLS = 128, ROWS = 32, HALF = 2, GUARD = 3;
  localparam int LATCH = 5, STEP = 4, ROW_CLKS = 900;
  localparam int LIT = ROW_CLKS - 3 * GUARD - LATCH - STEP;
  localparam int N_LATCH = 70, WD_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lum = 8'd255;
  logic [4:0] fb_row;
  logic [6:0] fb_col;
  logic       fb_pix, px_data, px_clk, col_strobe, frame_mark, row_step, drive_en;

  always #2 clk = ~clk;

  function automatic bit pix_model(int r, int c);
    return ((r * 13 + c * 7 + c / 9) % 5) < 2;
  endfunction

  function automatic int lit_expect(int b);
    int n = 0;
    for (int i = 0; i < LIT; i++) if ((i % 255) < b) n++;
    return n;
  endfunction

  assign fb_pix = pix_model(int'(fb_row), int'(fb_col));

  ledmx_refresh #(
    .COLS(COLS), .ROWS(ROWS), .DOT_HALF(HALF), .ROW_CLKS(ROW_CLKS),
    .GUARD_CLKS(GUARD), .LATCH_CLKS(LATCH), .STEP_CLKS(STEP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .lum_level(lum), .fb_row(fb_row), .fb_col(fb_col),
    .fb_pix(fb_pix), .px_data(px_data), .px_clk(px_clk), .col_strobe(col_strobe),
    .frame_mark(frame_mark), .row_step(row_step), .drive_en(drive_en)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int exp_rows[$];
  task automatic push_frame();
    for (int r = 0; r < ROWS; r++) exp_rows.push_back(r);
  endtask

  int b_list[10] = '{255, 0, 100, 117, 118, 1, 254, 37, 200, 128};

  bit         mon_on = 1'b0;
  int         cyc_total = 0;
  logic       p_dot = 0, p_lat = 0, p_step = 0, p_en = 0;
  int         dot_rises = 0, dot_hi = 0, lat_hi = 0, step_hi = 0;
  int         en_low = 0, since_edge = 0, lit_win = 0, row_cyc = 0;
  int         step_falls = 0, lat_rises = 0, lat_falls = 0, b_idx = 0;
  int         cur_b = 255, last_row = -1;
  logic [COLS-1:0] row_vec = '0;

  always @(negedge clk) begin
    cyc_total++;
    if (mon_on) begin
      bit edge_seen;
      edge_seen = 1'b0;
      en_low  = drive_en ? 0 : en_low + 1;
      lit_win += int'(drive_en);
      row_cyc++;
      if (px_clk && !p_dot) begin
        if (dot_rises < COLS) row_vec[dot_rises] = px_data;
        dot_rises++;
      end
      if (px_clk) dot_hi++;
      if (!px_clk && p_dot) begin
        chk(dot_hi == HALF, "R1", "dot high width", dot_hi, HALF);
        dot_hi = 0;
      end
      if (col_strobe) lat_hi++;
      if (row_step) step_hi++;
      if (col_strobe != p_lat) begin
        edge_seen = 1'b1;
        chk(en_low > GUARD, "R4", "enable-low run at strobe edge", en_low, GUARD + 1);
        if (col_strobe) begin
          chk(dot_rises == COLS, "R1", "dot rises in row", dot_rises, COLS);
          dot_rises = 0;
          if (lat_rises == 0)
            chk(lit_win == 0, "R7", "lit clocks before first latch", lit_win, 0);
          else
            chk(lit_win == lit_expect(cur_b), (cur_b == 0 || cur_b == 255) ? "R8" : "R9",
                "lit clocks in row window", lit_win, lit_expect(cur_b));
          lit_win = 0;
          lat_rises++;
          cur_b = b_list[b_idx % 10];
          b_idx++;
          lum = 8'(cur_b);
        end else begin
          int bad;
          chk(lat_hi == LATCH, "R3", "strobe width", lat_hi, LATCH);
          lat_hi = 0;
          lat_falls++;
          if (exp_rows.size() == 0) begin
            chk(1'b0, "R6", "scoreboard underrun", 0, 1);
          end else begin
            last_row = exp_rows.pop_front();
            chk(int'(fb_row) == last_row, "R2", "row read during latch", fb_row, last_row);
            bad = 0;
            for (int c = 0; c < COLS; c++) if (row_vec[c] != pix_model(last_row, c)) bad++;
            chk(bad == 0, "R2", "mismatched pixel bits in row", bad, 0);
          end
        end
      end
      if (row_step != p_step) begin
        edge_seen = 1'b1;
        chk(en_low > GUARD, "R4", "enable-low run at row clock edge", en_low, GUARD + 1);
        if (!row_step) begin
          chk(step_hi == STEP, "R5", "row clock width", step_hi, STEP);
          step_hi = 0;
          chk(frame_mark == (last_row == 0), "R6", "first-row marker", frame_mark, last_row == 0);
          if (step_falls > 0)
            chk(row_cyc == ROW_CLKS, "R5", "row clock period", row_cyc, ROW_CLKS);
          row_cyc = 0;
          step_falls++;
        end
      end
      if (col_strobe && px_clk) chk(1'b0, "R3", "strobe high with dot clock", 1, 0);
      since_edge = edge_seen ? 0 : since_edge + 1;
      if (drive_en && !p_en)
        chk(since_edge >= GUARD, "R4", "blank after last edge", since_edge, GUARD);
      p_dot = px_clk; p_lat = col_strobe; p_step = row_step; p_en = drive_en;
    end
  end

  initial begin
    push_frame();
    push_frame();
    push_frame();
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({px_data, px_clk, col_strobe, frame_mark, row_step, drive_en} == 6'b0,
          "R7", "outputs during reset",
          {px_data, px_clk, col_strobe, frame_mark, row_step, drive_en}, 0);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    while (lat_falls < N_LATCH && cyc_total < WD_CYC) @(negedge clk);
    if (cyc_total >= WD_CYC) chk(1'b0, "WATCHDOG", "latch count at timeout", lat_falls, N_LATCH);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule